// File: doc/BRIEF.md
# Codec Serial Port (Device Side)

This block is the device end of a synchronous serial link between a voice-band codec and a host processor. It divides the master clock by five to produce the serial clock, and it sends 16-bit words to the host, each one marked by a one-bit-period frame pulse from the device. It also receives 16-bit words from the host, each one framed by a pulse that the host drives. A host-driven flag, sampled with the last bit of each incoming word, sends that word either to the sample-data output or to an internal 16-bit control register. Bits 9:7 of the control register hold the output gain code.

All logic runs on the master clock and uses enable pulses taken from the divider. An active-high chip select enables the port. When chip select is low, the port drops its output enable so the pad ring can 3-state the pins, and it ignores all host traffic. In powerdown the serial clock keeps running, the device frame pulse stays low, and the data pin keeps the last bit it drove.

Top module: `codec_sport`

## Requirements
- R1: While rst_ni is low and cs_i is high, ser_clk_o, ser_data_o and ser_fs_o are 0, port_oe_o is 1, gain_o is 0 and data_valid_o is 0.
- R2: ser_clk_o has a period of 5 master clocks: it is high for 3 master clocks and then low for 2.
- R3: Each outgoing word is out_word_i, captured when ser_fs_o rises, and is sent as 16 bits, MSB first. ser_data_o changes only on a rising edge of ser_clk_o.
- R4: ser_fs_o is high for exactly one serial-clock period, the period just before the MSB. Frames start every 20 serial-clock periods. ser_data_o is 0 in the frame-pulse period and in the idle periods.
- R5: When ser_fs_i is sampled high on a falling edge of ser_clk_o, the next 16 falling-edge samples of ser_data_i form a word, MSB first. If dc_sel_i is 0 at the 16th sample, the word appears on data_o and data_valid_o pulses for one master clock.
- R6: If dc_sel_i is 1 at the 16th sample, the word is written to ctrl_o. data_o is unchanged and no data_valid_o pulse occurs.
- R7: gain_o always equals ctrl_o bits 9:7.
- R8: A ser_fs_i pulse sampled together with the LSB of a word commits that word and also starts the next word at once, so words can be sent back to back.
- R9: A ser_fs_i pulse sampled in the middle of a word discards the partial word and starts a new one.
- R10: While cs_i is 0, port_oe_o is 0 and incoming words are neither committed nor counted.
- R11: While pwrdn_i is 1, ser_clk_o keeps toggling, ser_fs_o is 0, ser_data_o holds its last value, and incoming words are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_i | input | 1 | Chip select, active high |
| pwrdn_i | input | 1 | Powerdown request |
| out_word_i | input | 16 | Next word to send to the host |
| ser_clk_o | output | 1 | Serial clock (master clock / 5) |
| ser_data_o | output | 1 | Serial data to the host |
| ser_fs_o | output | 1 | Frame pulse for outgoing words |
| port_oe_o | output | 1 | Drive enable for the three output pins |
| ser_data_i | input | 1 | Serial data from the host |
| ser_fs_i | input | 1 | Frame pulse from the host |
| dc_sel_i | input | 1 | Word routing: 0 sample data, 1 control |
| data_o | output | 16 | Last received sample word |
| data_valid_o | output | 1 | One-clock pulse when data_o updates |
| ctrl_o | output | 16 | Control register |
| gain_o | output | 3 | Output gain code, ctrl_o[9:7] |

## Verification
The receiver can see two events on the same falling edge: the commit of one word and the frame pulse that starts the next. The bench causes this by raising the host frame pulse during the LSB period of a word. It then checks that both back-to-back words land on data_o and that exactly two valid pulses occur. A second collision sends a frame pulse in the middle of a word. Here the bench expects the partial word to be dropped, only the following word to arrive, and exactly one valid pulse. Walking-one patterns in both directions, and a sweep of all eight gain codes, are compared with values the bench computes itself.

// File: rtl/codec_sport_pkg.sv
package codec_sport_pkg;
  localparam int SPORT_WORD_W   = 16;
  localparam int SPORT_DIV      = 5;
  localparam int SPORT_HIGH     = 3;
  localparam int SPORT_FRAME    = 20;
  localparam int SPORT_GAIN_LSB = 7;
  localparam int SPORT_GAIN_W   = 3;
endpackage

// File: rtl/sport_clkgen.sv
module sport_clkgen #(
  parameter int DIV  = 5,
  parameter int HIGH = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic sclk_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int CNT_W = $clog2(DIV);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic             sclk_q;

  always_comb cnt_nxt = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;

  // cnt == DIV-1 precedes the rising edge, so reset lands there with sclk low
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= LAST;
      sclk_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_nxt;
      sclk_q <= (cnt_nxt < CNT_W'(HIGH));
    end
  end

  assign rise_o = (cnt_q == LAST);
  assign fall_o = (cnt_q == CNT_W'(HIGH - 1));
  assign sclk_o = sclk_q;

  AST_SCLK_HOLD_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sclk_q) |=> sclk_q); // R2
  AST_SCLK_RISE_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> $rose(sclk_q)); // R2
endmodule

// File: rtl/sport_tx.sv
module sport_tx #(
  parameter int WORD_W = 16,
  parameter int FRAME  = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rise_i,
  input  logic              idle_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              sdo_o,
  output logic              fs_o
);
  localparam int POS_W = $clog2(FRAME);
  localparam logic [POS_W-1:0] LAST  = POS_W'(FRAME - 1);
  localparam logic [POS_W-1:0] WLAST = POS_W'(WORD_W);

  logic [POS_W-1:0]  pos_q, pos_nxt;
  logic [WORD_W-1:0] sh_q;
  logic              sdo_q, fs_q;

  always_comb pos_nxt = (pos_q == LAST) ? '0 : pos_q + 1'b1;

  // slot 0: frame pulse, slots 1..WORD_W: MSB..LSB, remaining slots idle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q <= LAST;
      sh_q  <= '0;
      sdo_q <= 1'b0;
      fs_q  <= 1'b0;
    end else if (rise_i) begin
      if (idle_i) begin
        pos_q <= LAST;    // restart with a fresh frame pulse; sdo holds
        fs_q  <= 1'b0;
      end else begin
        pos_q <= pos_nxt;
        fs_q  <= (pos_nxt == '0);
        if (pos_nxt == '0) begin
          sh_q  <= word_i;
          sdo_q <= 1'b0;
        end else if (pos_nxt <= WLAST) begin
          sdo_q <= sh_q[WORD_W-1];
          sh_q  <= sh_q << 1;
        end else begin
          sdo_q <= 1'b0;
        end
      end
    end
  end

  assign sdo_o = sdo_q;
  assign fs_o  = fs_q;

  AST_FS_ON_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fs_q) |-> $past(rise_i)); // R4
  AST_SDO_ON_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rise_i |=> $stable(sdo_q)); // R3
  AST_IDLE_FS_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_i && rise_i) |=> !fs_q); // R11
  AST_IDLE_SDO_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_i && rise_i) |=> $stable(sdo_q)); // R11
endmodule

// File: rtl/sport_rx.sv
module sport_rx #(
  parameter int WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fall_i,
  input  logic              idle_i,
  input  logic              sdi_i,
  input  logic              fs_i,
  input  logic              dc_i,
  output logic              commit_o,
  output logic              is_ctrl_o,
  output logic [WORD_W-1:0] word_o
);
  localparam int CNT_W = $clog2(WORD_W + 1);

  logic [CNT_W-1:0]  cnt_q;
  logic [WORD_W-2:0] sh_q;
  logic [WORD_W-1:0] word_q;
  logic              commit_q, is_ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      sh_q      <= '0;
      word_q    <= '0;
      commit_q  <= 1'b0;
      is_ctrl_q <= 1'b0;
    end else begin
      commit_q <= 1'b0;
      if (idle_i) begin
        cnt_q <= '0;
      end else if (fall_i) begin
        if (cnt_q != '0) begin
          sh_q  <= {sh_q[WORD_W-3:0], sdi_i};
          cnt_q <= cnt_q - 1'b1;
          if (cnt_q == CNT_W'(1)) begin
            commit_q  <= 1'b1;
            word_q    <= {sh_q, sdi_i};
            is_ctrl_q <= dc_i;
          end
        end
        // a frame pulse always (re)arms, dropping any partial word
        if (fs_i) cnt_q <= CNT_W'(WORD_W);
      end
    end
  end

  assign commit_o  = commit_q;
  assign is_ctrl_o = is_ctrl_q;
  assign word_o    = word_q;

  AST_COMMIT_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_q |-> $past(fall_i)); // R5
  AST_NO_COMMIT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_i |=> !commit_q); // R10
  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(WORD_W)); // R5
endmodule

// File: rtl/codec_sport.sv
module codec_sport
  import codec_sport_pkg::*;
#(
  parameter int WORD_W   = SPORT_WORD_W,
  parameter int DIV      = SPORT_DIV,
  parameter int HIGH     = SPORT_HIGH,
  parameter int FRAME    = SPORT_FRAME,
  parameter int GAIN_LSB = SPORT_GAIN_LSB,
  parameter int GAIN_W   = SPORT_GAIN_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_i,
  input  logic              pwrdn_i,
  input  logic [WORD_W-1:0] out_word_i,
  output logic              ser_clk_o,
  output logic              ser_data_o,
  output logic              ser_fs_o,
  output logic              port_oe_o,
  input  logic              ser_data_i,
  input  logic              ser_fs_i,
  input  logic              dc_sel_i,
  output logic [WORD_W-1:0] data_o,
  output logic              data_valid_o,
  output logic [WORD_W-1:0] ctrl_o,
  output logic [GAIN_W-1:0] gain_o
);
  logic              rise, fall, idle;
  logic              rx_commit, rx_is_ctrl;
  logic [WORD_W-1:0] rx_word;
  logic [WORD_W-1:0] data_q, ctrl_q;
  logic              dv_q;

  assign idle = pwrdn_i | ~cs_i;

  sport_clkgen #(.DIV(DIV), .HIGH(HIGH)) clkgen_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sclk_o (ser_clk_o),
    .rise_o (rise),
    .fall_o (fall)
  );

  sport_tx #(.WORD_W(WORD_W), .FRAME(FRAME)) tx_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rise_i (rise),
    .idle_i (idle),
    .word_i (out_word_i),
    .sdo_o  (ser_data_o),
    .fs_o   (ser_fs_o)
  );

  sport_rx #(.WORD_W(WORD_W)) rx_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .fall_i    (fall),
    .idle_i    (idle),
    .sdi_i     (ser_data_i),
    .fs_i      (ser_fs_i),
    .dc_i      (dc_sel_i),
    .commit_o  (rx_commit),
    .is_ctrl_o (rx_is_ctrl),
    .word_o    (rx_word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      ctrl_q <= '0;
      dv_q   <= 1'b0;
    end else begin
      dv_q <= 1'b0;
      if (rx_commit) begin
        if (rx_is_ctrl) begin
          ctrl_q <= rx_word;
        end else begin
          data_q <= rx_word;
          dv_q   <= 1'b1;
        end
      end
    end
  end

  assign port_oe_o    = cs_i;
  assign data_o       = data_q;
  assign data_valid_o = dv_q;
  assign ctrl_o       = ctrl_q;
  assign gain_o       = ctrl_q[GAIN_LSB +: GAIN_W];

  AST_DATA_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_commit && !rx_is_ctrl) |=> data_valid_o); // R5
  AST_CTRL_KEEPS_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_commit && rx_is_ctrl) |=> ($stable(data_q) && !data_valid_o)); // R6
  AST_CTRL_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rx_commit && rx_is_ctrl) |=> $stable(ctrl_q)); // R7
endmodule

// File: tb/codec_sport_tb_top.sv
module codec_sport_tb_top;
  localparam int CLK_P = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cs_i = 1'b1;
  logic        pwrdn_i = 1'b0;
  logic [15:0] out_word_i = '0;
  logic        ser_data_i = 1'b0;
  logic        ser_fs_i = 1'b0;
  logic        dc_sel_i = 1'b0;
  logic        ser_clk_o, ser_data_o, ser_fs_o, port_oe_o, data_valid_o;
  logic [15:0] data_o, ctrl_o;
  logic [2:0]  gain_o;

  int checks = 0;
  int errors = 0;
  int dv_cnt = 0;

  always #(CLK_P/2) clk_i = ~clk_i;

  codec_sport dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .cs_i(cs_i), .pwrdn_i(pwrdn_i),
    .out_word_i(out_word_i), .ser_clk_o(ser_clk_o), .ser_data_o(ser_data_o),
    .ser_fs_o(ser_fs_o), .port_oe_o(port_oe_o), .ser_data_i(ser_data_i),
    .ser_fs_i(ser_fs_i), .dc_sel_i(dc_sel_i), .data_o(data_o),
    .data_valid_o(data_valid_o), .ctrl_o(ctrl_o), .gain_o(gain_o)
  );

  always @(negedge clk_i) if (data_valid_o) dv_cnt++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // host: drive on serial clock rise, device samples on fall
  task automatic host_bit(input logic fs, input logic d, input logic dc);
    @(posedge ser_clk_o); #1;
    ser_fs_i = fs; ser_data_i = d; dc_sel_i = dc;
  endtask

  task automatic host_end();
    host_bit(1'b0, 1'b0, dc_sel_i);
    repeat (6) @(negedge clk_i);
  endtask

  task automatic host_word(input logic [15:0] w, input logic dc);
    host_bit(1'b1, 1'b0, dc);
    for (int i = 15; i >= 0; i--) host_bit(1'b0, w[i], dc);
    host_end();
  endtask

  task automatic tx_word(input logic [15:0] w);
    logic [15:0] got;
    logic        fs_bad;
    out_word_i = w;
    @(posedge ser_fs_o);
    @(negedge ser_clk_o); #1;
    chk("R4 fs in slot", ser_fs_o, 1);
    got = '0; fs_bad = 0;
    for (int i = 0; i < 16; i++) begin
      @(negedge ser_clk_o); #1;
      got = {got[14:0], ser_data_o};
      if (ser_fs_o) fs_bad = 1;
    end
    chk("R3 word", got, w);
    chk("R4 fs one period", fs_bad, 0);
    @(negedge ser_clk_o); #1;
    chk("R4 idle low", ser_data_o, 0);
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n_hi, n_lo, t0, t1, dv0, tog;
    logic [15:0] d0;
    logic held, moved, fs_seen, last_clk;

    // R1 reset state
    repeat (4) @(negedge clk_i);
    chk("R1 sclk", ser_clk_o, 0);
    chk("R1 sdo", ser_data_o, 0);
    chk("R1 fs", ser_fs_o, 0);
    chk("R1 oe", port_oe_o, 1);
    chk("R1 gain", gain_o, 0);
    chk("R1 valid", data_valid_o, 0);
    rst_ni = 1'b1;

    // R2 clock shape
    @(posedge ser_clk_o);
    n_hi = 0; n_lo = 0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk_i);
      if (ser_clk_o) n_hi++; else n_lo++;
    end
    chk("R2 high", n_hi, 3);
    chk("R2 low", n_lo, 2);

    // R4 frame period
    @(posedge ser_fs_o); t0 = $time;
    @(posedge ser_fs_o); t1 = $time;
    chk("R4 frame period", (t1 - t0) / CLK_P, 100);

    // R3 walking ones and patterns out
    for (int i = 0; i < 16; i++) tx_word(16'h1 << i);
    tx_word(16'hA5C3);
    tx_word(16'hFFFF);
    tx_word(16'h0000);

    // R5 walking ones in, data path
    for (int i = 0; i < 16; i++) begin
      dv0 = dv_cnt;
      host_word(16'h1 << i, 1'b0);
      chk("R5 data", data_o, 16'h1 << i);
      chk("R5 valid pulses", dv_cnt - dv0, 1);
    end
    host_word(16'h5AF0, 1'b0);
    chk("R5 data pattern", data_o, 16'h5AF0);

    // R6 R7 control words sweep every gain code
    for (int g = 0; g < 8; g++) begin
      dv0 = dv_cnt;
      host_word(16'(g << 7) | 16'h8001, 1'b1);
      chk("R6 ctrl", ctrl_o, 16'(g << 7) | 16'h8001);
      chk("R6 data kept", data_o, 16'h5AF0);
      chk("R6 no valid", dv_cnt - dv0, 0);
      chk("R7 gain", gain_o, g);
    end

    // R8 back to back: new fs with LSB
    dv0 = dv_cnt;
    host_bit(1'b1, 1'b0, 1'b0);
    for (int i = 15; i >= 1; i--) host_bit(1'b0, 16'h3C69 >> i, 1'b0);
    host_bit(1'b1, 1'b1, 1'b0);  // LSB of 0x3C69 is 1
    for (int i = 15; i >= 0; i--) host_bit(1'b0, 16'hC396 >> i, 1'b0);
    host_end();
    chk("R8 second word", data_o, 16'hC396);
    chk("R8 two valids", dv_cnt - dv0, 2);

    // R9 mid-word restart
    dv0 = dv_cnt;
    host_bit(1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 5; i++) host_bit(1'b0, 1'b1, 1'b0);
    host_bit(1'b1, 1'b1, 1'b0);
    for (int i = 15; i >= 0; i--) host_bit(1'b0, 16'h0F0F >> i, 1'b0);
    host_end();
    chk("R9 data", data_o, 16'h0F0F);
    chk("R9 one valid", dv_cnt - dv0, 1);

    // R10 chip select low
    cs_i = 1'b0;
    #1 chk("R10 oe", port_oe_o, 0);
    dv0 = dv_cnt;
    host_word(16'h1234, 1'b0);
    host_word(16'h0380, 1'b1);
    chk("R10 data kept", data_o, 16'h0F0F);
    chk("R10 no valid", dv_cnt - dv0, 0);
    chk("R10 gain kept", gain_o, 7);
    cs_i = 1'b1;

    // R11 powerdown mid-word
    out_word_i = 16'hFFFF;
    @(posedge ser_fs_o);
    repeat (4) @(negedge ser_clk_o);
    @(negedge clk_i); pwrdn_i = 1'b1;
    #1 held = ser_data_o;
    chk("R11 mid-word bit", held, 1);
    moved = 0; fs_seen = 0; tog = 0; last_clk = ser_clk_o;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk_i);
      if (ser_data_o !== held) moved = 1;
      if (ser_fs_o && i > 5) fs_seen = 1;
      if (ser_clk_o !== last_clk) tog++;
      last_clk = ser_clk_o;
    end
    chk("R11 sdo hold", moved, 0);
    chk("R11 fs low", fs_seen, 0);
    chk("R11 clock runs", tog >= 20, 1);
    d0 = data_o; dv0 = dv_cnt;
    host_word(16'h0000, 1'b1);
    host_word(16'hBEEF, 1'b0);
    chk("R11 gain kept", gain_o, 7);
    chk("R11 data kept", data_o, d0);
    chk("R11 no valid", dv_cnt - dv0, 0);
    pwrdn_i = 1'b0;
    tx_word(16'h6A95);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule